// File: doc/BRIEF.md
# Integer Multiply and Multiply-Accumulate Unit

This unit sits in the execute stage of a 32-bit processor and handles the whole multiply family of instructions. Each cycle it may receive an instruction word together with the register operands that the word names: the two factors, an addend for the short forms, and the current low and high halves of the destination pair for the long forms. It checks whether the word belongs to the family, decodes the operation, computes the result, and one cycle later presents the result words, the destination register numbers, the write enables and, when requested, new negative and zero flags.

The short forms keep only the low 32 bits of the product. Those bits are the same whether the factors are read as signed or unsigned, so these forms do not depend on signedness and give no overflow indication. The long forms keep all 64 bits, so their signedness matters. All forms share one multiplier. Combinations that the encoding reserves are reported as undefined, and they write nothing.

The unit also returns the read addresses of the two factors, taken straight from the instruction word, and it passes the condition field along with the result so that a later stage can evaluate it.

Top module: `mac_unit`

## Requirements
- R1: A word is a family member when bits 27:24 are 0000 and bits 7:4 are 1001. `resValid` rises exactly one cycle after a strobed member. A non-member, or a cycle with no strobe, gives `resValid` low and no writes. The condition field (bits 31:28) is returned on `resCond` with the result.
- R2: Operation field bits 23:21 = 000 (plain multiply) writes the low 32 bits of the product to register bits 19:16 through the low write port. The high port is not written. The low word is the same for signed and unsigned readings of the factors.
- R3: Code 001 writes addend + low product bits. Code 011 writes addend − low product bits. The addend comes from `opA`, the register that bits 15:12 name. Result and destination are as in R2.
- R4: Codes 100 (unsigned long multiply) and 101 (unsigned long multiply-accumulate) zero-extend the factors. Code 101 also adds the 64-bit value {`opHi`,`opLo`}. The low word goes to register bits 15:12 and the high word to register bits 19:16, and both ports are written.
- R5: Codes 110 and 111 behave like 100 and 101, except that they sign-extend both factors.
- R6: Code 010 (unsigned double-accumulate) writes product + `opLo` + `opHi`, all unsigned, as a 64-bit pair. The destinations are as in R4. With all three inputs at 0xFFFFFFFF the result is 0xFFFFFFFF_FFFFFFFF, so the sum never wraps.
- R7: When bit 20 is set on a legal member, `flagWr` is high. `flagN` is then the top bit of the result: bit 31 for the short forms, bit 63 for the long forms. `flagZ` is set when the whole result is zero. When bit 20 is clear, `flagWr` is low.
- R8: A member with bit 20 set and code 010 or 011, or with code 000 and a non-zero bits 15:12, raises `undef` along with `resValid`. It drives every write enable and `flagWr` low.
- R9: After reset, every registered output is zero.
- R10: `srcIdxN` equals bits 3:0 and `srcIdxM` equals bits 11:8 of the present instruction word, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| opN | input | 32 | First factor (register named by bits 3:0) |
| opM | input | 32 | Second factor (register named by bits 11:8) |
| opA | input | 32 | Addend for the short accumulate forms |
| opLo | input | 32 | Current low destination word for the long forms |
| opHi | input | 32 | Current high destination word for the long forms |
| srcIdxN | output | 4 | Read address of the first factor |
| srcIdxM | output | 4 | Read address of the second factor |
| resValid | output | 1 | A decoded member completed last cycle |
| undef | output | 1 | Reserved encoding; all writes suppressed |
| resCond | output | 4 | Condition field of the completed instruction |
| wrLoEn | output | 1 | Write enable, low or only result word |
| wrLoIdx | output | 4 | Destination of the low word |
| resLo | output | 32 | Low or only result word |
| wrHiEn | output | 1 | Write enable, high result word |
| wrHiIdx | output | 4 | Destination of the high word |
| resHi | output | 32 | High result word |
| flagWr | output | 1 | Flag update enable |
| flagN | output | 1 | New negative flag |
| flagZ | output | 1 | New zero flag |

## Verification
Assertions check the protocol on every cycle. An undefined encoding never writes. The high port is only ever written together with the low one. Flags change only alongside a valid result, and `flagN`/`flagZ` always agree with the result words that were written. `resValid` follows a strobed member by exactly one cycle. The arithmetic itself can only be shown by the bench's scenarios. These include the low-word equivalence of signed and unsigned products, the high words that differ with signedness, the borrow of multiply-subtract, the signed accumulation that wraps to zero, and the all-ones double-accumulate.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;

  typedef enum logic [2:0] {
    OP_MUL   = 3'b000,
    OP_MLA   = 3'b001,
    OP_DACC  = 3'b010,
    OP_MLS   = 3'b011,
    OP_UMUL  = 3'b100,
    OP_UMAC  = 3'b101,
    OP_SMUL  = 3'b110,
    OP_SMAC  = 3'b111
  } macOp_e;

  typedef struct packed {
    logic             hit;
    logic             undef;
    logic             isLong;
    logic             accA;
    logic             sub;
    logic             accPair;
    logic             accDual;
    logic             signedMul;
    logic             setFlags;
    logic [3:0]       cond;
    logic [IDX_W-1:0] loIdx;
    logic [IDX_W-1:0] hiIdx;
  } macStrobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [31:0]   instr,
  output logic [IW-1:0] srcIdxN,
  output logic [IW-1:0] srcIdxM,
  output macStrobe_t    strobe
);
  macOp_e op;
  logic   sBit;
  logic   raZero;

  always_comb begin
    op      = macOp_e'(instr[23:21]);
    sBit    = instr[20];
    raZero  = (instr[15:12] == 4'd0);
    srcIdxN = instr[3:0];
    srcIdxM = instr[11:8];

    strobe.hit       = (instr[27:24] == 4'b0000) && (instr[7:4] == 4'b1001);
    strobe.undef     = strobe.hit &&
                       ((sBit && (op == OP_DACC || op == OP_MLS)) ||
                        (op == OP_MUL && !raZero));
    strobe.isLong    = instr[23] || (op == OP_DACC);
    strobe.accA      = (op == OP_MLA) || (op == OP_MLS);
    strobe.sub       = (op == OP_MLS);
    strobe.accPair   = (op == OP_UMAC) || (op == OP_SMAC);
    strobe.accDual   = (op == OP_DACC);
    strobe.signedMul = (op == OP_SMUL) || (op == OP_SMAC);
    strobe.setFlags  = sBit;
    strobe.cond      = instr[31:28];
    strobe.hiIdx     = instr[19:16];
    strobe.loIdx     = strobe.isLong ? instr[15:12] : instr[19:16];
  end
endmodule

// File: rtl/mac_dpath.sv
module mac_dpath
  import mac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  macStrobe_t    strobe,
  input  logic [DW-1:0] opN,
  input  logic [DW-1:0] opM,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opLo,
  input  logic [DW-1:0] opHi,
  output logic          resValid,
  output logic          undef,
  output logic [3:0]    resCond,
  output logic          wrLoEn,
  output logic [IW-1:0] wrLoIdx,
  output logic [DW-1:0] resLo,
  output logic          wrHiEn,
  output logic [IW-1:0] wrHiIdx,
  output logic [DW-1:0] resHi,
  output logic          flagWr,
  output logic          flagN,
  output logic          flagZ
);
  localparam int PW = 2 * DW + 2;
  localparam int LW = 2 * DW;

  logic [DW:0]     extN, extM;
  logic [PW-1:0]   wideN, wideM, prodW;
  logic [LW-1:0]   prod, accBase, longSum;
  logic [DW-1:0]   shortRes, loNext, hiNext;
  logic            nNext, zNext, legal;

  always_comb begin
    extN     = {strobe.signedMul & opN[DW-1], opN};
    extM     = {strobe.signedMul & opM[DW-1], opM};
    wideN    = {{(DW+1){extN[DW]}}, extN};
    wideM    = {{(DW+1){extM[DW]}}, extM};
    prodW    = wideN * wideM;
    prod     = prodW[LW-1:0];
    if (strobe.accPair)      accBase = {opHi, opLo};
    else if (strobe.accDual) accBase = {{DW{1'b0}}, opLo} + {{DW{1'b0}}, opHi};
    else                     accBase = '0;
    longSum  = prod + accBase;
    if (!strobe.accA)        shortRes = prod[DW-1:0];
    else if (strobe.sub)     shortRes = opA - prod[DW-1:0];
    else                     shortRes = opA + prod[DW-1:0];
    loNext   = strobe.isLong ? longSum[DW-1:0] : shortRes;
    hiNext   = strobe.isLong ? longSum[LW-1:DW] : '0;
    nNext    = strobe.isLong ? longSum[LW-1] : shortRes[DW-1];
    zNext    = strobe.isLong ? (longSum == '0) : (shortRes == '0);
    legal    = inValid && strobe.hit && !strobe.undef;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      undef    <= 1'b0;
      resCond  <= '0;
      wrLoEn   <= 1'b0;
      wrHiEn   <= 1'b0;
      wrLoIdx  <= '0;
      wrHiIdx  <= '0;
      resLo    <= '0;
      resHi    <= '0;
      flagWr   <= 1'b0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
    end else begin
      resValid <= inValid && strobe.hit;
      undef    <= inValid && strobe.undef;
      wrLoEn   <= legal;
      wrHiEn   <= legal && strobe.isLong;
      flagWr   <= legal && strobe.setFlags;
      if (inValid) begin
        resCond <= strobe.cond;
        wrLoIdx <= strobe.loIdx;
        wrHiIdx <= strobe.hiIdx;
        resLo   <= loNext;
        resHi   <= hiNext;
        flagN   <= nNext;
        flagZ   <= zNext;
      end
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.hit) |=> resValid);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && strobe.hit) |=> !resValid);
  // R8
  undef_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    undef |-> (resValid && !wrLoEn && !wrHiEn && !flagWr));
  // R4
  hi_with_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrHiEn |-> wrLoEn);
  // R7
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWr |-> (resValid && wrLoEn));
  // R7
  flag_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && wrHiEn) |-> (flagN == resHi[DW-1] && flagZ == ({resHi, resLo} == '0)));
  // R7
  flag_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && !wrHiEn) |-> (flagN == resLo[DW-1] && flagZ == (resLo == '0)));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [31:0]   instr,
  input  logic [DW-1:0] opN,
  input  logic [DW-1:0] opM,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opLo,
  input  logic [DW-1:0] opHi,
  output logic [IW-1:0] srcIdxN,
  output logic [IW-1:0] srcIdxM,
  output logic          resValid,
  output logic          undef,
  output logic [3:0]    resCond,
  output logic          wrLoEn,
  output logic [IW-1:0] wrLoIdx,
  output logic [DW-1:0] resLo,
  output logic          wrHiEn,
  output logic [IW-1:0] wrHiIdx,
  output logic [DW-1:0] resHi,
  output logic          flagWr,
  output logic          flagN,
  output logic          flagZ
);
  macStrobe_t strobe;

  mac_ctrl #(.IW(IW)) uCtrl (
    .instr(instr), .srcIdxN(srcIdxN), .srcIdxM(srcIdxM), .strobe(strobe)
  );

  mac_dpath #(.DW(DW), .IW(IW)) uDpath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe),
    .opN(opN), .opM(opM), .opA(opA), .opLo(opLo), .opHi(opHi),
    .resValid(resValid), .undef(undef), .resCond(resCond),
    .wrLoEn(wrLoEn), .wrLoIdx(wrLoIdx), .resLo(resLo),
    .wrHiEn(wrHiEn), .wrHiIdx(wrHiIdx), .resHi(resHi),
    .flagWr(flagWr), .flagN(flagN), .flagZ(flagZ)
  );
endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opN = '0, opM = '0, opA = '0, opLo = '0, opHi = '0;
  logic [3:0]  srcIdxN, srcIdxM, resCond, wrLoIdx, wrHiIdx;
  logic        resValid, undef, wrLoEn, wrHiEn, flagWr, flagN, flagZ;
  logic [31:0] resLo, resHi;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mac_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .opN(opN), .opM(opM), .opA(opA), .opLo(opLo), .opHi(opHi),
    .srcIdxN(srcIdxN), .srcIdxM(srcIdxM), .resValid(resValid), .undef(undef),
    .resCond(resCond), .wrLoEn(wrLoEn), .wrLoIdx(wrLoIdx), .resLo(resLo),
    .wrHiEn(wrHiEn), .wrHiIdx(wrHiIdx), .resHi(resHi),
    .flagWr(flagWr), .flagN(flagN), .flagZ(flagZ)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        s;
    logic [3:0]  hiF;
    logic [3:0]  loF;
    logic [31:0] n, m, a, lo, hi, eLo, eHi;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 4'd3,  4'd0, 32'h12345678, 32'h8,        32'h0,        32'h0, 32'h0,        32'h91A2B3C0, 32'h0},        // R2
    '{3'b000, 1'b1, 4'd4,  4'd0, 32'h12345678, 32'hFFFFFFF8, 32'h0,        32'h0, 32'h0,        32'h6E5D4C40, 32'h0},        // R2 R7
    '{3'b100, 1'b1, 4'd5,  4'd6, 32'h12345678, 32'hFFFFFFF8, 32'h0,        32'h0, 32'h0,        32'h6E5D4C40, 32'h12345677}, // R4
    '{3'b110, 1'b1, 4'd7,  4'd8, 32'h12345678, 32'hFFFFFFF8, 32'h0,        32'h0, 32'h0,        32'h6E5D4C40, 32'hFFFFFFFF}, // R5
    '{3'b001, 1'b0, 4'd9,  4'd2, 32'h3,        32'h5,        32'hA,        32'h0, 32'h0,        32'h19,       32'h0},        // R3
    '{3'b011, 1'b0, 4'd10, 4'd2, 32'h3,        32'h5,        32'hA,        32'h0, 32'h0,        32'hFFFFFFFB, 32'h0},        // R3
    '{3'b001, 1'b1, 4'd11, 4'd1, 32'h2,        32'h3,        32'hFFFFFFFA, 32'h0, 32'h0,        32'h0,        32'h0},        // R3 R7
    '{3'b101, 1'b0, 4'd12, 4'd13,32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h1, 32'h0,        32'h00000002, 32'hFFFFFFFE}, // R4
    '{3'b111, 1'b1, 4'd14, 4'd15,32'hFFFFFFFF, 32'h2,        32'h0,        32'h2, 32'h0,        32'h0,        32'h0},        // R5 R7
    '{3'b010, 1'b0, 4'd1,  4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R6
    '{3'b110, 1'b0, 4'd2,  4'd3, 32'h80000000, 32'h80000000, 32'h0,        32'h0, 32'h0,        32'h0,        32'h40000000}, // R5
    '{3'b100, 1'b1, 4'd6,  4'd5, 32'h0,        32'h5,        32'h0,        32'h0, 32'h0,        32'h0,        32'h0},        // R4 R7
    '{3'b111, 1'b0, 4'd8,  4'd9, 32'hFFFFFFFE, 32'h3,        32'h0,        32'h10, 32'h0,       32'hA,        32'h0},        // R5
    '{3'b101, 1'b1, 4'd0,  4'd7, 32'h2,        32'h3,        32'h0,        32'h0, 32'h80000000, 32'h6,        32'h80000000}  // R4 R7
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] cond, input logic [2:0] op, input logic s,
                                      input logic [3:0] hiF, input logic [3:0] loF,
                                      input logic [3:0] mF, input logic [3:0] nF);
    return {cond, 4'b0000, op, s, hiF, loF, mF, 4'b1001, nF};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [31:0] n, input logic [31:0] m,
                       input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    instr = w; opN = n; opM = m; opA = a; opLo = lo; opHi = hi; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic isLong;
    logic [3:0] expLoIdx;
    repeat (2) @(negedge clk);
    // R9: reset state
    check(!resValid && !undef && !wrLoEn && !wrHiEn && !flagWr && resLo == 0 && resHi == 0 && resCond == 0,
          "R9 reset outputs", {resLo, resHi}, 64'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      isLong = v.op[2] || (v.op == 3'b010);
      expLoIdx = isLong ? v.loF : v.hiF;
      issue(enc(4'hE, v.op, v.s, v.hiF, v.loF, 4'd6, 4'd9), v.n, v.m, v.a, v.lo, v.hi);
      check(resValid && !undef && resCond == 4'hE, "R1 valid after member", {63'h0, resValid}, 64'h1);
      check(resLo == v.eLo, "R2 R3 R4 R5 R6 low word", resLo, v.eLo);
      check(wrLoEn && wrLoIdx == expLoIdx, "R2 R4 low destination", wrLoIdx, expLoIdx);
      check(wrHiEn == isLong, "R2 R4 high enable", wrHiEn, isLong);
      if (isLong) begin
        check(resHi == v.eHi && wrHiIdx == v.hiF, "R4 R5 R6 high word", {resHi, 28'h0, wrHiIdx}, {v.eHi, 28'h0, v.hiF});
      end
      check(flagWr == v.s, "R7 flag enable", flagWr, v.s);
      if (v.s) begin
        check(flagN == (isLong ? v.eHi[31] : v.eLo[31]), "R7 negative flag", flagN, isLong ? v.eHi[31] : v.eLo[31]);
        check(flagZ == (isLong ? ({v.eHi, v.eLo} == 0) : (v.eLo == 0)), "R7 zero flag", flagZ,
              isLong ? ({v.eHi, v.eLo} == 0) : (v.eLo == 0));
      end
    end

    // R10: source indices from the word
    @(negedge clk);
    instr = enc(4'h0, 3'b000, 1'b0, 4'd1, 4'd0, 4'hC, 4'h5);
    #1;
    check(srcIdxN == 4'h5 && srcIdxM == 4'hC, "R10 source indices", {srcIdxN, srcIdxM}, 8'h5C);

    // R8: reserved combinations
    issue(enc(4'hE, 3'b011, 1'b1, 4'd3, 4'd2, 4'd6, 4'd9), 32'h3, 32'h5, 32'hA, 0, 0);
    check(resValid && undef && !wrLoEn && !wrHiEn && !flagWr, "R8 flagged subtract",
          {resValid, undef, wrLoEn, wrHiEn, flagWr}, 5'b11000);
    issue(enc(4'hE, 3'b010, 1'b1, 4'd3, 4'd2, 4'd6, 4'd9), 32'h3, 32'h5, 0, 0, 0);
    check(resValid && undef && !wrLoEn && !wrHiEn && !flagWr, "R8 flagged double-accumulate",
          {resValid, undef, wrLoEn, wrHiEn, flagWr}, 5'b11000);
    issue(enc(4'hE, 3'b000, 1'b0, 4'd3, 4'd5, 4'd6, 4'd9), 32'h3, 32'h5, 0, 0, 0);
    check(resValid && undef && !wrLoEn && !wrHiEn && !flagWr, "R8 plain with nonzero Ra field",
          {resValid, undef, wrLoEn, wrHiEn, flagWr}, 5'b11000);

    // R1: non-member (bits 7:4 = 1011) gives nothing
    issue({4'hE, 4'b0000, 3'b000, 1'b1, 4'd3, 4'd0, 4'd6, 4'b1011, 4'd9}, 32'h3, 32'h5, 0, 0, 0);
    check(!resValid && !wrLoEn && !wrHiEn && !flagWr && !undef, "R1 non-member ignored",
          {resValid, wrLoEn, wrHiEn, flagWr}, 4'b0000);
    // R1: non-member (bits 27:24 = 0001)
    issue({4'hE, 4'b0001, 3'b000, 1'b0, 4'd3, 4'd0, 4'd6, 4'b1001, 4'd9}, 32'h3, 32'h5, 0, 0, 0);
    check(!resValid && !wrLoEn, "R1 wrong top field ignored", {resValid, wrLoEn}, 2'b00);
    // R1: member without strobe
    @(negedge clk);
    instr = enc(4'hE, 3'b000, 1'b0, 4'd3, 4'd0, 4'd6, 4'd9);
    @(negedge clk);
    check(!resValid && !wrLoEn, "R1 no strobe no result", {resValid, wrLoEn}, 2'b00);

    // R9: reset mid-run clears outputs
    issue(enc(4'hE, 3'b100, 1'b1, 4'd3, 4'd4, 4'd6, 4'd9), 32'h7, 32'h7, 0, 0, 0);
    rstN = 1'b0;
    #1;
    check(!resValid && !wrLoEn && !wrHiEn && !flagWr && resLo == 0 && resHi == 0, "R9 reset clears",
          {resLo, resHi}, 64'h0);
    rstN = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule